// File: doc/BRIEF.md
# Link Round-Trip Delay Measurement Unit

This unit measures two delay components of a serial link in cycles of a fast measurement clock. A run is armed by a start request. The first transmit word that equals a programmable trigger character starts a timer, and the first later receive word that carries the same character stops it. The cycle difference between the two word strobes is the round-trip figure. The clock edge that registers each trigger word is the time reference, not the data transition.

The transmit words that follow the trigger are counted in hyperframes of programmable length. The offset figure is the number of cycles from the receive trigger to the next transmit hyperframe boundary. Both figures are 16 bits wide and are read back one byte at a time through a registered select port. A done flag, an overflow flag and a valid flag report the state of the run. Valid is high only while both link sides report lock.

All word strobes are synchronous to the measurement clock.

Top module: `rtd_top`

## Requirements
- R1: A start pulse with `meas_en`, `tx_lock` and `rx_lock` all high is accepted in any state. From the next cycle, `done` and `ovf` are low, both results read back as 0, and the unit is armed.
- R2: A start pulse is ignored while `meas_en` or either lock is low. `done`, `ovf` and both results keep their values.
- R3: The trigger character resets to 10'h0FA, the K28.5 comma. A cycle with `trig_wr` high loads `trig_wdata` as the new trigger, and from then on the old character no longer triggers.
- R4: Once armed, the timer starts at the first cycle with `tx_stb` high and `tx_word` equal to the trigger. It stops at the first later cycle with `rx_stb` high and `rx_word` equal to the trigger. The round-trip result is the cycle count between these two cycles. A receive trigger seen before the transmit trigger is ignored.
- R5: Transmit strobes after the trigger word are indexed modulo `hf_len`, counting the trigger word as index 0. A hyperframe boundary is a strobe whose index wraps back to 0. `hf_len` must be at least 1.
- R6: The offset result is the number of cycles from the receive trigger to the first hyperframe boundary in the same or a later cycle. It is 0 when both fall in the same cycle.
- R7: `done` rises in the cycle after the edge that completes the run, which is the boundary capture or a saturation.
- R8: Each timer is 16 bits and saturates at 16'hFFFF. If the awaited event has not arrived by the time the count reaches 16'hFFFF, that result becomes 16'hFFFF and `ovf` and `done` are set.
- R9: If `meas_en` or either lock goes low while a run is in progress, the run is abandoned. `done` stays low until the next accepted start.
- R10: `valid` is high in a cycle only if `done` is high and both locks were high at the preceding edge.
- R11: `rd_data` is registered from `rd_sel` with one cycle of latency. The select codes are 0 = round-trip low byte, 1 = round-trip high byte, 2 = offset low byte, 3 = offset high byte.
- R12: Results and flags hold their values after a run until the next accepted start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Measurement clock |
| rst | input | 1 | Synchronous active-high reset |
| meas_en | input | 1 | Measurement enable |
| tx_lock | input | 1 | Transmit side locked to valid framing |
| rx_lock | input | 1 | Receive side locked to valid framing |
| start | input | 1 | Start or restart request pulse |
| trig_wr | input | 1 | Load a new trigger character |
| trig_wdata | input | 10 | New trigger character |
| hf_len | input | 8 | Hyperframe length in words |
| tx_stb | input | 1 | Transmit word strobe |
| tx_word | input | 10 | Transmit word |
| rx_stb | input | 1 | Receive word strobe |
| rx_word | input | 10 | Receive word |
| rd_sel | input | 2 | Result byte select |
| rd_data | output | 8 | Selected result byte, registered |
| done | output | 1 | Run complete |
| valid | output | 1 | Results valid under lock |
| ovf | output | 1 | A timer saturated before its stop event |

## Verification
A stop event at cycle c makes `done` high from c+1. The checks sample 1 ns after the edge that ends cycle c-1, where `done` must still be low, and after the edge that ends cycle c, where `done` must be high and `valid` with it. A result byte is due one edge after `rd_sel` changes and is sampled 1 ns after that edge. The sweep drives trigger delays, hyperframe lengths and strobe spacings, and derives the expected round-trip and offset arithmetically from the cycle numbers at which the bench placed the events. Saturation is checked at count 16'hFFFF with the cycle-exact position of the stop.

// File: rtl/rtd_pkg.sv
package rtd_pkg;
  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_ARM  = 3'd1,
    ST_RTT  = 3'd2,
    ST_BND  = 3'd3,
    ST_DONE = 3'd4
  } rtd_state_t;

  // K28.5 comma, running disparity negative
  localparam logic [9:0] RTD_COMMA = 10'h0FA;
endpackage

// File: rtl/rtd_match.sv
module rtd_match #(
  parameter int WORD_W = 10
) (
  input  logic              stb,
  input  logic [WORD_W-1:0] word,
  input  logic [WORD_W-1:0] pat,
  output logic              hit
);
  assign hit = stb && (word == pat);
endmodule

// File: rtl/rtd_timer.sv
module rtd_timer #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic             run,
  output logic [CNT_W-1:0] cnt,
  output logic             sat
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  assign sat = &cnt;

  always_ff @(posedge clk) begin
    if (rst)
      cnt <= '0;
    else if (load)
      cnt <= ONE;
    else if (run && !sat)
      cnt <= cnt + ONE;
  end

  // R8: a saturated count stays saturated until reloaded
  p_sat_hold_r8: assert property (@(posedge clk) disable iff (rst)
    (sat && !load) |=> sat);

  // R4: a load starts the count at one
  p_load_one_r4: assert property (@(posedge clk) disable iff (rst)
    load |=> (cnt == ONE));
endmodule

// File: rtl/rtd_hfcnt.sv
module rtd_hfcnt #(
  parameter int HF_W = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            load,
  input  logic            run,
  input  logic            stb,
  input  logic [HF_W-1:0] hf_len,
  output logic            bnd
);
  logic [HF_W-1:0] idx;
  logic            last;

  assign last = (idx == hf_len - HF_W'(1));
  assign bnd  = run && stb && last && !load;

  always_ff @(posedge clk) begin
    if (rst)
      idx <= '0;
    else if (load)
      idx <= '0;
    else if (run && stb)
      idx <= last ? '0 : idx + HF_W'(1);
  end

  // R5: a boundary strobe restarts the word index
  p_wrap_r5: assert property (@(posedge clk) disable iff (rst)
    bnd |=> (idx == '0));
endmodule

// File: rtl/rtd_top.sv
module rtd_top
  import rtd_pkg::*;
#(
  parameter int               WORD_W   = 10,
  parameter int               HF_W     = 8,
  parameter int               BYTE_W   = 8,
  parameter logic [WORD_W-1:0] TRIG_RST = RTD_COMMA
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              meas_en,
  input  logic              tx_lock,
  input  logic              rx_lock,
  input  logic              start,
  input  logic              trig_wr,
  input  logic [WORD_W-1:0] trig_wdata,
  input  logic [HF_W-1:0]   hf_len,
  input  logic              tx_stb,
  input  logic [WORD_W-1:0] tx_word,
  input  logic              rx_stb,
  input  logic [WORD_W-1:0] rx_word,
  input  logic [1:0]        rd_sel,
  output logic [BYTE_W-1:0] rd_data,
  output logic              done,
  output logic              valid,
  output logic              ovf
);
  localparam int CNT_W = 2 * BYTE_W;
  localparam int NPATH = 2;

  rtd_state_t        state, nxt;
  logic [WORD_W-1:0] trig_q;
  logic [CNT_W-1:0]  rt_q, off_q, rt_cnt, off_cnt;
  logic              rt_sat, off_sat, bnd;
  logic              lock_ok, start_ok, busy;
  logic              rt_load, off_load, fin, set_ovf, cap_rt, cap_off, off_zero;
  logic              done_n;

  logic [NPATH-1:0]              p_stb, p_hit;
  logic [NPATH-1:0][WORD_W-1:0]  p_word;

  assign p_stb  = {rx_stb, tx_stb};
  assign p_word = {rx_word, tx_word};

  generate
    for (genvar g = 0; g < NPATH; g++) begin : g_match
      rtd_match #(.WORD_W(WORD_W)) i_match (
        .stb (p_stb[g]),
        .word(p_word[g]),
        .pat (trig_q),
        .hit (p_hit[g])
      );
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst)
      trig_q <= TRIG_RST;
    else if (trig_wr)
      trig_q <= trig_wdata;
  end

  assign lock_ok  = tx_lock && rx_lock;
  assign start_ok = start && meas_en && lock_ok;
  assign busy     = (state == ST_ARM) || (state == ST_RTT) || (state == ST_BND);

  always_comb begin
    nxt      = state;
    rt_load  = 1'b0;
    off_load = 1'b0;
    fin      = 1'b0;
    set_ovf  = 1'b0;
    cap_rt   = 1'b0;
    cap_off  = 1'b0;
    off_zero = 1'b0;
    if (start_ok) begin
      nxt = ST_ARM;
    end else if (busy && !(meas_en && lock_ok)) begin
      nxt = ST_IDLE;
    end else begin
      case (state)
        ST_ARM: if (p_hit[0]) begin
          nxt     = ST_RTT;
          rt_load = 1'b1;
        end
        ST_RTT: if (p_hit[1]) begin
          cap_rt   = 1'b1;
          off_load = 1'b1;
          if (bnd) begin
            off_zero = 1'b1;
            fin      = 1'b1;
            nxt      = ST_DONE;
          end else begin
            nxt = ST_BND;
          end
        end else if (rt_sat) begin
          cap_rt  = 1'b1;
          set_ovf = 1'b1;
          fin     = 1'b1;
          nxt     = ST_DONE;
        end
        ST_BND: if (bnd || off_sat) begin
          cap_off = 1'b1;
          set_ovf = !bnd;
          fin     = 1'b1;
          nxt     = ST_DONE;
        end
        default: ;
      endcase
    end
  end

  assign done_n = start_ok ? 1'b0 : (done || fin);

  rtd_timer #(.CNT_W(CNT_W)) i_rt_timer (
    .clk (clk),
    .rst (rst),
    .load(rt_load),
    .run (state == ST_RTT),
    .cnt (rt_cnt),
    .sat (rt_sat)
  );

  rtd_timer #(.CNT_W(CNT_W)) i_off_timer (
    .clk (clk),
    .rst (rst),
    .load(off_load),
    .run (state == ST_BND),
    .cnt (off_cnt),
    .sat (off_sat)
  );

  rtd_hfcnt #(.HF_W(HF_W)) i_hfcnt (
    .clk   (clk),
    .rst   (rst),
    .load  (rt_load),
    .run   ((state == ST_RTT) || (state == ST_BND)),
    .stb   (tx_stb),
    .hf_len(hf_len),
    .bnd   (bnd)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ST_IDLE;
      rt_q  <= '0;
      off_q <= '0;
      done  <= 1'b0;
      ovf   <= 1'b0;
      valid <= 1'b0;
    end else begin
      state <= nxt;
      done  <= done_n;
      valid <= done_n && lock_ok;
      if (start_ok) begin
        rt_q  <= '0;
        off_q <= '0;
        ovf   <= 1'b0;
      end else begin
        if (cap_rt)   rt_q  <= rt_cnt;
        if (off_zero) off_q <= '0;
        if (cap_off)  off_q <= off_cnt;
        if (set_ovf)  ovf   <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst)
      rd_data <= '0;
    else
      case (rd_sel)
        2'd0:    rd_data <= rt_q[BYTE_W-1:0];
        2'd1:    rd_data <= rt_q[CNT_W-1:BYTE_W];
        2'd2:    rd_data <= off_q[BYTE_W-1:0];
        default: rd_data <= off_q[CNT_W-1:BYTE_W];
      endcase
  end

  // R1: an accepted start clears the flags and arms the unit
  p_start_clear_r1: assert property (@(posedge clk) disable iff (rst)
    (start && meas_en && tx_lock && rx_lock) |=> (!done && !ovf && state == ST_ARM));

  // R2: with no accepted start, an idle unit stays idle
  p_ignore_r2: assert property (@(posedge clk) disable iff (rst)
    (!(start && meas_en && tx_lock && rx_lock) && state == ST_IDLE) |=> state == ST_IDLE);

  // R7: done can only rise out of a measuring state
  p_done_src_r7: assert property (@(posedge clk) disable iff (rst)
    $rose(done) |-> $past(state == ST_RTT || state == ST_BND));

  // R8: overflow is only reported with a finished run
  p_ovf_done_r8: assert property (@(posedge clk) disable iff (rst)
    ovf |-> done);

  // R10: valid requires lock at the previous edge
  p_valid_lock_r10: assert property (@(posedge clk) disable iff (rst)
    valid |-> $past(tx_lock && rx_lock));

  // R12: finished results hold until an accepted start
  p_hold_r12: assert property (@(posedge clk) disable iff (rst)
    (state == ST_DONE && !(start && meas_en && tx_lock && rx_lock))
      |=> ($stable(rt_q) && $stable(off_q) && done));
endmodule

// File: tb/test_rtd_top.sv
`timescale 1ns/1ps
module test_rtd_top;
  localparam logic [9:0] K285 = 10'h0FA;
  localparam logic [9:0] ALT  = 10'h305;
  localparam logic [9:0] FILL = 10'h155;

  logic       clk = 1'b0;
  logic       rst, meas_en, tx_lock, rx_lock, start, trig_wr;
  logic [9:0] trig_wdata, tx_word, rx_word;
  logic [7:0] hf_len, rd_data;
  logic       tx_stb, rx_stb, done, valid, ovf;
  logic [1:0] rd_sel;

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;

  always #2.5 clk = ~clk;

  rtd_top i_rtd_top (
    .clk(clk), .rst(rst), .meas_en(meas_en), .tx_lock(tx_lock), .rx_lock(rx_lock),
    .start(start), .trig_wr(trig_wr), .trig_wdata(trig_wdata), .hf_len(hf_len),
    .tx_stb(tx_stb), .tx_word(tx_word), .rx_stb(rx_stb), .rx_word(rx_word),
    .rd_sel(rd_sel), .rd_data(rd_data), .done(done), .valid(valid), .ovf(ovf)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic idle_in();
    @(negedge clk);
    start = 1'b0; trig_wr = 1'b0;
    tx_stb = 1'b0; rx_stb = 1'b0; tx_word = FILL; rx_word = FILL;
  endtask

  task automatic pulse_start();
    @(negedge clk);
    start = 1'b1; tx_stb = 1'b0; rx_stb = 1'b0;
    tick();
    @(negedge clk);
    start = 1'b0;
  endtask

  // R11: low byte at select 2*which, high byte at 2*which+1
  task automatic read16(input int which, output int val);
    int lo;
    @(negedge clk);
    rd_sel = 2'(2 * which);
    tick();
    lo = rd_data;
    @(negedge clk);
    rd_sel = 2'(2 * which + 1);
    tick();
    val = (int'(rd_data) << 8) | lo;
  endtask

  task automatic run_case(input int d, input int hf, input int p, input bit early);
    int len, k, stop, off_e, v;
    hf_len = 8'(hf);
    pulse_start();
    len   = hf * p;
    k     = (d + len - 1) / len;
    stop  = k * len;
    off_e = stop - d;
    for (int c = 0; c <= stop + 1; c++) begin
      @(negedge clk);
      tx_stb  = (c % p == 0);
      tx_word = (c == 0) ? K285 : FILL;
      rx_stb  = 1'b1;
      rx_word = (c == d || (early && c == 0)) ? K285 : FILL;
      tick();
      if (c == stop - 1) chk(done == 1'b0, "R7 done early", int'(done), 0);
      if (c == stop) begin
        chk(done == 1'b1, "R7 done timing", int'(done), 1);
        chk(valid == 1'b1, "R10 valid with lock", int'(valid), 1);
      end
    end
    idle_in();
    read16(0, v);
    chk(v == d, "R4 round-trip", v, d);
    read16(1, v);
    chk(v == off_e, "R6/R5 offset", v, off_e);
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 190000) begin
        n_fail++;
        n_chk++;
        $display("FAIL watchdog actual=%0d expected=%0d", cyc, 190000);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
      end
    end
  end

  initial begin
    int v, v2;
    rst = 1'b1; meas_en = 1'b1; tx_lock = 1'b1; rx_lock = 1'b1; start = 1'b0;
    trig_wr = 1'b0; trig_wdata = '0; hf_len = 8'd1; tx_stb = 1'b0; rx_stb = 1'b0;
    tx_word = FILL; rx_word = FILL; rd_sel = 2'd0;
    repeat (3) tick();
    @(negedge clk);
    rst = 1'b0;
    tick();
    chk(done == 1'b0, "reset done", int'(done), 0);
    chk(valid == 1'b0, "reset valid", int'(valid), 0);
    chk(ovf == 1'b0, "reset ovf", int'(ovf), 0);
    chk(rd_data == 8'd0, "reset rd_data", int'(rd_data), 0);

    // R4 R5 R6 R3 sweep with the default trigger character
    for (int p = 1; p <= 2; p++)
      for (int hf = 1; hf <= 4; hf++)
        for (int d = 1; d <= 20; d++)
          run_case(d, hf, p, p == 2);

    // R12: results hold over idle cycles
    repeat (20) tick();
    read16(0, v);
    chk(v == 20, "R12 hold rt", v, 20);
    chk(done == 1'b1, "R12 hold done", int'(done), 1);

    // R10: lock loss drops valid while done stays
    @(negedge clk);
    tx_lock = 1'b0;
    tick();
    tick();
    chk(valid == 1'b0, "R10 valid without lock", int'(valid), 0);
    chk(done == 1'b1, "R10 done kept", int'(done), 1);

    // R2: start ignored without lock, then without enable
    pulse_start();
    tick();
    chk(done == 1'b1, "R2 start ignored lock", int'(done), 1);
    @(negedge clk);
    tx_lock = 1'b1; meas_en = 1'b0;
    pulse_start();
    tick();
    chk(done == 1'b1, "R2 start ignored enable", int'(done), 1);
    read16(0, v);
    chk(v == 20, "R2 result kept", v, 20);
    @(negedge clk);
    meas_en = 1'b1;

    // R1: accepted start clears results and flags
    pulse_start();
    chk(done == 1'b0, "R1 done cleared", int'(done), 0);
    read16(0, v);
    read16(1, v2);
    chk(v == 0 && v2 == 0, "R1 results cleared", v + v2, 0);

    // R9: lock drop mid-run abandons the run
    for (int c = 0; c <= 12; c++) begin
      @(negedge clk);
      tx_stb  = 1'b1;
      tx_word = (c == 0) ? K285 : FILL;
      rx_stb  = 1'b1;
      rx_word = (c == 7) ? K285 : FILL;
      rx_lock = !(c >= 3 && c < 5);
      tick();
    end
    idle_in();
    chk(done == 1'b0, "R9 run abandoned", int'(done), 0);
    read16(0, v);
    chk(v == 0, "R9 no result", v, 0);

    // R3: new trigger character replaces the comma
    @(negedge clk);
    trig_wr = 1'b1; trig_wdata = ALT;
    tick();
    @(negedge clk);
    trig_wr = 1'b0;
    hf_len = 8'd1;
    pulse_start();
    for (int c = 0; c <= 9; c++) begin
      @(negedge clk);
      tx_stb  = 1'b1;
      tx_word = (c == 0) ? K285 : ((c == 2) ? ALT : FILL);
      rx_stb  = 1'b1;
      rx_word = (c == 4) ? K285 : ((c == 7) ? ALT : FILL);
      tick();
    end
    idle_in();
    read16(0, v);
    chk(v == 5, "R3 new trigger rt", v, 5);
    read16(1, v);
    chk(v == 0, "R3 new trigger offset", v, 0);

    // R8: round-trip timer saturation
    pulse_start();
    for (int c = 0; c <= 65536; c++) begin
      @(negedge clk);
      tx_stb  = (c == 0);
      tx_word = (c == 0) ? ALT : FILL;
      rx_stb  = 1'b0;
      tick();
      if (c == 65534) chk(done == 1'b0, "R8 not yet saturated", int'(done), 0);
    end
    idle_in();
    chk(done == 1'b1, "R8 done on saturation", int'(done), 1);
    chk(ovf == 1'b1, "R8 overflow flag", int'(ovf), 1);
    read16(0, v);
    chk(v == 65535, "R8 saturated rt", v, 65535);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule